// File: doc/BRIEF.md
# HDMI Transmitter Power-Up Configuration Sequencer

This block brings an external HDMI transmitter into a usable state straight after reset, with no processor involved. It holds the two-wire bus idle for a power-up delay, then walks a fixed list of register/value pairs. For each pair it issues one complete bus write: a START condition, the 8-bit write address, the register index, the value, and a STOP condition. Every byte is followed by an acknowledge slot that the sequencer samples. The list powers up the transmitter's main block first. It then selects 24-bit RGB input at 8 bits per component, passes RGB straight through with no colour conversion, fixes the aspect bit, and selects plain DVI output with encryption off. Audio, general-control and deep-colour registers are never touched. Of the transmitter's 36 pixel inputs only 24 carry RGB. Four inputs at the bottom of each 12-bit group are left unused.

The bus pins are open drain. The block only pulls a line low or lets it go, and it reads back the data line to see acknowledges. Each SCL bit period is split into four equal quarters, set by a divider. SDA moves only in the first quarter, while SCL is low. SCL is high in the middle two quarters and low again in the last. A write whose acknowledge is missing ends with a STOP and is repeated, up to three extra times. If the fourth attempt also fails, the block raises `cfg_error` and leaves the bus idle for good. After the last pair is acknowledged it raises `cfg_done`, which stays set.

The control FSM has five states. POWERUP counts the delay, then goes to LAUNCH. LAUNCH pulses a start to the byte engine and goes to WAIT_XFER. WAIT_XFER waits for the engine's end-of-write. It goes to LAUNCH again on a retry or on the next pair, to DONE after the last pair, and to FAIL when retries run out. DONE and FAIL are terminal. The byte engine has five states. IDLE moves to START on a start pulse. START moves to BIT. BIT moves to ACK after the 8th bit. ACK moves back to BIT for the next byte, or to STOP after the third byte or on a missing acknowledge. STOP returns to IDLE. Every transition except IDLE to START is taken at the end of the fourth quarter.

Top module: `video_tx_init_seq`

## Requirements
- R1: While reset is held, both bus lines are released and `cfg_done` and `cfg_error` are low.
- R2: After reset, neither line is pulled low for at least CLK_HZ*PWRUP_MS/1000 clock cycles (200 ms at defaults). The first START follows within a few bit quarters of that.
- R3: Each write is a START (SDA falls while SCL is high), then three bytes sent MSB first, then a STOP (SDA rises while SCL is high). The bytes are {DEV_ADDR,0} (0x72 at default), the register index and the value. Apart from START and STOP, SDA never changes while SCL is high.
- R4: The writes go out in this order, as register←value: 0x41←0x10 (main block power-up), 0x15←0x00, 0x16←0x30 (bits [5:4]=11, the other bits at their default 0), 0x17←0x00, 0x18←0x00 (conversion off, bit 7 = 0), 0xAF←0x04 (bit 1 = 0 for DVI, bit 7 = 0 for encryption off).
- R5: Exactly six writes complete in a clean run, and none targets register 0x4C.
- R6: The acknowledge is sampled while SCL is high in the ninth clock of every byte. SDA high there counts as a missing acknowledge, and the write ends at once with a STOP.
- R7: A write with a missing acknowledge is repeated for the same pair, up to MAX_RETRY (3) extra times. A success on the last allowed attempt continues the list normally.
- R8: If MAX_RETRY+1 attempts at one pair all miss their acknowledge, `cfg_error` rises and stays high, `cfg_done` stays low, and the bus stays released with no further START.
- R9: After the last pair is acknowledged, `cfg_done` rises and stays high and the bus stays idle.
- R10: Every SCL high pulse inside a write lasts exactly 2*QTR cycles, where QTR = CLK_HZ/(4*SCL_HZ) (125 cycles at defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sda_in | input | 1 | Level read back from the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_done | output | 1 | All pairs written and acknowledged (sticky) |
| cfg_error | output | 1 | Retries used up on one pair (sticky) |

## Verification
The bench builds a small configuration of 800 Hz clock and 100 Hz SCL. This gives two clock cycles per quarter and a 160-cycle power-up wait. A bus target model decodes every START, byte and STOP and logs each acknowledged write. A clean run checks the byte stream, the table order, the power-up gap and the pulse widths. The bench then sweeps each of the six pairs with exactly three and exactly four refused address bytes. Three refusals must still end in DONE with nine STARTs. Four refusals must end in FAIL with only the earlier pairs logged. The sweep tells apart an off-by-one in the retry limit, a wrong table position, and a failure to stop the bus after an error.

// File: rtl/vti_pkg.sv
package vti_pkg;

    localparam int NUM_PAIRS = 6;

    typedef struct packed {
        logic [7:0] reg_idx;
        logic [7:0] value;
    } cfg_pair_t;

    typedef enum logic [2:0] {
        E_IDLE,
        E_START,
        E_BIT,
        E_ACK,
        E_STOP
    } eng_state_t;

    typedef enum logic [2:0] {
        T_POWERUP,
        T_LAUNCH,
        T_WAIT_XFER,
        T_DONE,
        T_FAIL
    } ctl_state_t;

    // Fixed configuration list; first entry wakes the main block.
    function automatic cfg_pair_t pair_at(input int idx);
        cfg_pair_t p;
        unique case (idx)
            0:       p = '{reg_idx: 8'h41, value: 8'h10};
            1:       p = '{reg_idx: 8'h15, value: 8'h00};
            2:       p = '{reg_idx: 8'h16, value: 8'h30};
            3:       p = '{reg_idx: 8'h17, value: 8'h00};
            4:       p = '{reg_idx: 8'h18, value: 8'h00};
            default: p = '{reg_idx: 8'hAF, value: 8'h04};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/vti_quarter_tick.sv
module vti_quarter_tick #(
    parameter int QTR = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);

    generate
        if (QTR > 1) begin : g_spacing
            // R10: quarters are evenly spaced, never back to back
            a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/vti_byte_engine.sv
module vti_byte_engine
    import vti_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            start,
    input  logic [2:0][7:0] bytes_in,
    input  logic            sda_in,
    output logic            scl_low,
    output logic            sda_low,
    output logic            xfer_done,
    output logic            xfer_nack
);
    eng_state_t      state;
    logic [1:0]      phase;
    logic [1:0]      byte_idx;
    logic [2:0]      bit_idx;
    logic [2:0][7:0] bytes_q;
    logic            ack_miss;
    logic [7:0]      cur_byte;
    logic            cur_bit;
    logic            quarter_end;

    assign quarter_end = tick && (phase == 2'd3);

    // State register, counters and acknowledge capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= E_IDLE;
            phase     <= '0;
            byte_idx  <= '0;
            bit_idx   <= '0;
            bytes_q   <= '0;
            ack_miss  <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            unique case (state)
                E_IDLE: begin
                    if (start) begin
                        state    <= E_START;
                        phase    <= '0;
                        byte_idx <= '0;
                        bit_idx  <= 3'd7;
                        bytes_q  <= bytes_in;
                        ack_miss <= 1'b0;
                    end
                end
                E_START: begin
                    if (tick) phase <= phase + 1'b1;
                    if (quarter_end) state <= E_BIT;
                end
                E_BIT: begin
                    if (tick) phase <= phase + 1'b1;
                    if (quarter_end) begin
                        if (bit_idx == 3'd0) begin
                            state <= E_ACK;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                        end
                    end
                end
                E_ACK: begin
                    if (tick) phase <= phase + 1'b1;
                    if (tick && phase == 2'd2) ack_miss <= sda_in;
                    if (quarter_end) begin
                        if (ack_miss || byte_idx == 2'd2) begin
                            state <= E_STOP;
                        end else begin
                            state    <= E_BIT;
                            byte_idx <= byte_idx + 1'b1;
                            bit_idx  <= 3'd7;
                        end
                    end
                end
                E_STOP: begin
                    if (tick) phase <= phase + 1'b1;
                    if (quarter_end) begin
                        state     <= E_IDLE;
                        xfer_done <= 1'b1;
                    end
                end
                default: state <= E_IDLE;
            endcase
        end
    end

    assign xfer_nack = ack_miss;

    always_comb begin
        unique case (byte_idx)
            2'd0:    cur_byte = bytes_q[0];
            2'd1:    cur_byte = bytes_q[1];
            default: cur_byte = bytes_q[2];
        endcase
        cur_bit = cur_byte[bit_idx];
    end

    // Line drive per state and quarter
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        unique case (state)
            E_IDLE: begin
                scl_low = 1'b0;
                sda_low = 1'b0;
            end
            E_START: begin
                scl_low = (phase == 2'd3);
                sda_low = (phase != 2'd0);
            end
            E_BIT: begin
                scl_low = (phase == 2'd0) || (phase == 2'd3);
                sda_low = !cur_bit;
            end
            E_ACK: begin
                scl_low = (phase == 2'd0) || (phase == 2'd3);
                sda_low = 1'b0;
            end
            E_STOP: begin
                scl_low = (phase == 2'd0);
                sda_low = (phase < 2'd2);
            end
            default: begin
                scl_low = 1'b0;
                sda_low = 1'b0;
            end
        endcase
    end

    // R3: data stays put while the clock is high within a bit
    a_r3_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == E_BIT && $past(state) == E_BIT && !scl_low && !$past(scl_low))
        |-> $stable(sda_low));

    // R6: a missing acknowledge leads straight to STOP
    a_r6_nack_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == E_ACK && quarter_end && ack_miss) |=> (state == E_STOP));

    // R3: the acknowledge slot never pulls SDA
    a_r3_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == E_ACK) |-> !sda_low);

endmodule

// File: rtl/video_tx_init_seq.sv
module video_tx_init_seq
    import vti_pkg::*;
#(
    parameter int          CLK_HZ    = 50_000_000,
    parameter int          SCL_HZ    = 100_000,
    parameter int          PWRUP_MS  = 200,
    parameter int          MAX_RETRY = 3,
    parameter logic [6:0]  DEV_ADDR  = 7'h39
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    output logic scl_drive_low,
    output logic sda_drive_low,
    output logic cfg_done,
    output logic cfg_error
);
    localparam int          QTR       = CLK_HZ / (4 * SCL_HZ);
    localparam longint      WAIT_L    = (longint'(CLK_HZ) * longint'(PWRUP_MS)) / 64'd1000;
    localparam int unsigned WAIT_CYC  = (WAIT_L > 0) ? int'(WAIT_L) : 1;
    localparam int          WCW       = $clog2(WAIT_CYC + 1);
    localparam logic [WCW-1:0] WAIT_LAST = WCW'(WAIT_CYC - 1);
    localparam int          IW        = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
    localparam int          RW        = $clog2(MAX_RETRY + 1) + 1;
    localparam logic [7:0]  ADDR_WR   = {DEV_ADDR, 1'b0};

    ctl_state_t      state;
    logic [WCW-1:0]  wait_cnt;
    logic [IW-1:0]   pair_idx;
    logic [RW-1:0]   retry_cnt;
    logic            tick;
    logic            xfer_start;
    logic            xfer_done;
    logic            xfer_nack;
    cfg_pair_t       pair;
    logic [2:0][7:0] xfer_bytes;

    vti_quarter_tick #(.QTR(QTR)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    always_comb begin
        pair       = pair_at(int'(pair_idx));
        xfer_bytes = {pair.value, pair.reg_idx, ADDR_WR};
    end

    vti_byte_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (xfer_start),
        .bytes_in  (xfer_bytes),
        .sda_in    (sda_in),
        .scl_low   (scl_drive_low),
        .sda_low   (sda_drive_low),
        .xfer_done (xfer_done),
        .xfer_nack (xfer_nack)
    );

    // Control state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= T_POWERUP;
            wait_cnt  <= '0;
            pair_idx  <= '0;
            retry_cnt <= '0;
        end else begin
            unique case (state)
                T_POWERUP: begin
                    if (wait_cnt == WAIT_LAST) begin
                        state <= T_LAUNCH;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                T_LAUNCH: state <= T_WAIT_XFER;
                T_WAIT_XFER: begin
                    if (xfer_done) begin
                        if (xfer_nack) begin
                            if (retry_cnt == RW'(MAX_RETRY)) begin
                                state <= T_FAIL;
                            end else begin
                                retry_cnt <= retry_cnt + 1'b1;
                                state     <= T_LAUNCH;
                            end
                        end else if (pair_idx == IW'(NUM_PAIRS - 1)) begin
                            state <= T_DONE;
                        end else begin
                            pair_idx  <= pair_idx + 1'b1;
                            retry_cnt <= '0;
                            state     <= T_LAUNCH;
                        end
                    end
                end
                T_DONE:  state <= T_DONE;
                T_FAIL:  state <= T_FAIL;
                default: state <= T_FAIL;
            endcase
        end
    end

    // Control outputs
    always_comb begin
        xfer_start = 1'b0;
        cfg_done   = 1'b0;
        cfg_error  = 1'b0;
        unique case (state)
            T_POWERUP:   ;
            T_LAUNCH:    xfer_start = 1'b1;
            T_WAIT_XFER: ;
            T_DONE:      cfg_done   = 1'b1;
            T_FAIL:      cfg_error  = 1'b1;
            default:     ;
        endcase
    end

    // R1: outcome flags never both set
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_done && cfg_error));

    // R2: bus untouched during the power-up wait
    a_r2_quiet_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_POWERUP) |-> (!scl_drive_low && !sda_drive_low));

    // R7: attempts per pair bounded
    a_r7_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        retry_cnt <= RW'(MAX_RETRY));

    // R8: error is sticky and leaves the bus released
    a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> (cfg_error && !cfg_done));
    a_r8_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> (!scl_drive_low && !sda_drive_low));

    // R9: done is sticky and leaves the bus released
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);
    a_r9_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> (!scl_drive_low && !sda_drive_low));

endmodule

// File: tb/tb_video_tx_init_seq.sv
module tb_video_tx_init_seq;
    localparam int CLK_HZ = 800;
    localparam int SCL_HZ = 100;
    localparam int QTR    = CLK_HZ / (4 * SCL_HZ);
    localparam int WAITC  = CLK_HZ * 200 / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_oe, sda_oe, done, err;
    logic ack_drv = 1'b0;
    wire  scl_line = !scl_oe;
    wire  sda_line = !(sda_oe || ack_drv);

    always #2 clk = !clk;

    video_tx_init_seq #(
        .CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .PWRUP_MS(200),
        .MAX_RETRY(3), .DEV_ADDR(7'h39)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_line),
        .scl_drive_low(scl_oe), .sda_drive_low(sda_oe),
        .cfg_done(done), .cfg_error(err)
    );

    int n_checks = 0;
    int n_fail = 0;
    int wd = 0;

    int exp_reg [6] = '{8'h41, 8'h15, 8'h16, 8'h17, 8'h18, 8'hAF};
    int exp_val [6] = '{8'h10, 8'h00, 8'h30, 8'h00, 8'h00, 8'h04};

    // bus target model state
    logic slv_clr = 1'b1;
    int   target = -1;
    int   nack_n = 0;
    int   nacks_given, starts, stops, logged, first_start, rel_cyc, bad_w, rise_cyc;
    int   bitcnt, bytecnt;
    bit   in_txn, ack_ph, rise_ok, ack_all, p_scl, p_sda;
    logic [7:0] shreg;
    logic [7:0] by [4];
    logic [7:0] lg_a [8];
    logic [7:0] lg_r [8];
    logic [7:0] lg_v [8];

    always @(negedge clk) begin
        wd++;
        if (slv_clr) begin
            nacks_given = 0; starts = 0; stops = 0; logged = 0;
            first_start = -1; rel_cyc = 0; bad_w = 0; rise_cyc = 0;
            bitcnt = 0; bytecnt = 0; in_txn = 0; ack_ph = 0; rise_ok = 0;
            ack_all = 1; p_scl = 1; p_sda = 1; ack_drv = 1'b0; shreg = '0;
        end else begin
            rel_cyc++;
            if (p_scl && scl_line && p_sda && !sda_line) begin
                starts++;
                if (first_start < 0) first_start = rel_cyc;
                in_txn = 1; bitcnt = 0; bytecnt = 0; ack_ph = 0;
                rise_ok = 0; ack_all = 1;
            end else if (p_scl && scl_line && !p_sda && sda_line) begin
                stops++;
                if (in_txn && bytecnt == 3 && ack_all && logged < 8) begin
                    lg_a[logged] = by[0]; lg_r[logged] = by[1]; lg_v[logged] = by[2];
                    logged++;
                end
                in_txn = 0; rise_ok = 0;
            end else if (!p_scl && scl_line) begin
                if (in_txn) begin
                    rise_cyc = rel_cyc; rise_ok = 1;
                    if (!ack_ph && bitcnt < 8) begin
                        shreg = {shreg[6:0], sda_line};
                        bitcnt++;
                    end
                end
            end else if (p_scl && !scl_line) begin
                if (rise_ok && (rel_cyc - rise_cyc) != 2 * QTR) bad_w++;
                rise_ok = 0;
                if (in_txn) begin
                    if (ack_ph) begin
                        ack_ph = 0; ack_drv = 1'b0; bitcnt = 0;
                        if (bytecnt < 4) by[bytecnt] = shreg;
                        bytecnt++;
                    end else if (bitcnt == 8) begin
                        ack_ph = 1;
                        if (bytecnt == 0 && logged == target && nacks_given < nack_n) begin
                            ack_drv = 1'b0; nacks_given++; ack_all = 0;
                        end else begin
                            ack_drv = 1'b1;
                        end
                    end
                end
            end
            p_scl = scl_line;
            p_sda = sda_line;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic do_reset(input int tgt, input int nn);
        @(negedge clk);
        rst_n = 1'b0; slv_clr = 1'b1; target = tgt; nack_n = nn;
        repeat (4) @(negedge clk);
        chk(!scl_oe && !sda_oe && !done && !err, "R1", "reset outputs",
            {scl_oe, sda_oe, done, err}, 0);
        rst_n = 1'b1; slv_clr = 1'b0;
    endtask

    task automatic run_to_end();
        int n = 0;
        while (!done && !err && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic quiet_check(input string req);
        int s0 = starts;
        repeat (300) @(negedge clk);
        chk(starts == s0 && !scl_oe && !sda_oe, req, "bus idle after end", starts, s0);
    endtask

    initial begin
        // clean run: R2 R3 R4 R5 R9 R10
        do_reset(-1, 0);
        run_to_end();
        chk(done == 1'b1 && err == 1'b0, "R9", "done after clean run", {done, err}, 2);
        chk(first_start >= WAITC && first_start <= WAITC + 6 * QTR, "R2",
            "first START cycle", first_start, WAITC);
        chk(logged == 6 && starts == 6, "R5", "write count", logged, 6);
        for (int i = 0; i < 6; i++) begin
            chk(lg_a[i] == 8'h72, "R3", "address byte", lg_a[i], 8'h72);
            chk(lg_r[i] == exp_reg[i][7:0], "R4", "register order", lg_r[i], exp_reg[i]);
            chk(lg_v[i] == exp_val[i][7:0], "R4", "register value", lg_v[i], exp_val[i]);
            chk(lg_r[i] != 8'h4C, "R5", "no 0x4C write", lg_r[i], 8'h4C);
        end
        chk(bad_w == 0, "R10", "SCL high width", bad_w, 0);
        chk(stops == starts, "R3", "STOP per START", stops, starts);
        quiet_check("R9");

        // retry sweep over every pair
        for (int k = 0; k < 6; k++) begin
            // three refusals: last allowed attempt succeeds (R7)
            do_reset(k, 3);
            run_to_end();
            chk(done && !err, "R7", "done after 3 refusals", {done, err}, 2);
            chk(starts == 9 && logged == 6, "R7", "attempts with 3 refusals", starts, 9);
            chk(lg_r[k] == exp_reg[k][7:0], "R7", "retried pair", lg_r[k], exp_reg[k]);
            chk(stops == starts, "R6", "refused write ends with STOP", stops, starts);

            // four refusals: error (R8)
            do_reset(k, 4);
            run_to_end();
            chk(err && !done, "R8", "error after 4 refusals", {done, err}, 1);
            chk(starts == k + 4 && logged == k, "R8", "attempts before error", starts, k + 4);
            chk(stops == starts, "R6", "STOP after refusal", stops, starts);
            quiet_check("R8");
            chk(err && !done, "R8", "error sticky", {done, err}, 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (wd > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected<=150000", wd);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule